// File: doc/BRIEF.md
# Grouped priority interrupt controller

This block gathers interrupt requests into twenty-five groups of four lanes each and presents them to a processor. Groups 0 and 1 are non-maskable. Any new request in those groups raises a one-cycle pulse on a dedicated output. Groups 2 to 24 are maskable. Each of them holds four request bits, four enable bits and a three-bit priority level. A resolver picks the group with the smallest level among those that have an enabled pending request, and drives that level to the processor. Level 7 is the lowest priority and also means that nothing is pending.

Request lanes arrive as single-cycle set pulses from trigger logic outside the block. Lane `i` of the flat input vector belongs to group `i/4`, lane `i%4`. Software reaches the groups over a byte-wide register bus, with one 8-byte window per group. When the processor accepts an interrupt, it asserts an acknowledge together with the level it saw. The block then latches the winning group into an accepted-group register, which software can read to find the source.

Top module: `grp_irq_ctrl`

## Requirements
- R1: A set pulse on input lane `g*4+k` sets request bit `k` of group `g` at the next clock edge. The bit stays set until a register write clears it.
- R2: For a maskable group, a read of address `g*8+0` returns the request bits in 7:4 and (request AND enable) in 3:0.
- R3: For a maskable group, address `g*8+1` is read/write. It holds the level in bits 6:4 and the enables in bits 3:0, and bit 7 reads 0.
- R4: A write of `w` to byte 0 of a maskable group sets the requests to `(req & w[3:0]) | (w[7:4] & w[3:0])`. A set pulse arriving in the same cycle is still recorded.
- R5: For a non-maskable group, byte 0 reads the requests in bits 3:0 and 0 in bits 7:4. Writing 1 to a bit clears that request. Byte 1 reads 0 and ignores writes.
- R6: `nmi_o` is high in exactly those cycles that follow a cycle in which any non-maskable lane had a set pulse.
- R7: `level_o` equals the smallest level among maskable groups with an enabled pending request, or 7 when there is none. It reflects the register state right after each clock edge.
- R8: When several groups share the winning level, the lowest-numbered group wins.
- R9: On `ack_i` with `ack_level_i == level_o`, the winning group is latched (group 0 if none). Address 240 reads that group number shifted left by 2 while the group still has an enabled pending request, and 0 otherwise. Writes to address 240 are ignored.
- R10: An acknowledge whose level differs from `level_o` sets `ack_err_o`, which stays set until reset. The latched group is left unchanged.
- R11: After reset, every group has requests 0, enables 1111 and level 7. `level_o` is 7, `nmi_o` and `ack_err_o` are 0, and address 240 reads 0.
- R12: All other addresses read 0 and ignore writes. This covers byte offsets 2 to 7 in any group, and group windows above 24 other than address 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_req_i | input | 100 | Per-lane set-request pulses, lane g*4+k |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational from address |
| ack_i | input | 1 | Processor acknowledge |
| ack_level_i | input | 3 | Level the processor accepted |
| level_o | output | 3 | Current winning level, 7 when idle |
| nmi_o | output | 1 | Non-maskable interrupt pulse |
| ack_err_o | output | 1 | Sticky acknowledge level mismatch |

## Verification
Request, enable, level and accepted-group state all update on the rising edge that samples the pulse, write or acknowledge. `level_o` and the readback data follow that state with no further register, so both are due right after that edge. `nmi_o` comes from one register and is also due right after the edge that sampled the pulse. The bench drives every input on the falling edge and advances its model on the rising edge, using the level the model held before that edge to judge an acknowledge. It compares all outputs at the next falling edge, so every result is checked exactly one half-period after the edge that produces it.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int LANES = 4;
  localparam int LVL_W = 3;
  typedef logic [LVL_W-1:0] lvl_t;
  typedef logic [LANES-1:0] lane_t;
  localparam lvl_t LVL_IDLE = 3'd7;
endpackage

// File: rtl/icu_group.sv
module icu_group
  import icu_pkg::*;
#(
  parameter bit IS_NMI = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  lane_t      set_i,
  input  logic       wr0_i,
  input  logic       wr1_i,
  input  logic [7:0] wdata_i,
  output lane_t      req_o,
  output lane_t      en_o,
  output lvl_t       lvl_o
);
  lane_t req_q, en_q, req_keep;
  lvl_t  lvl_q;

  always_comb begin
    req_keep = req_q;
    if (wr0_i) begin
      if (IS_NMI) req_keep = req_q & ~wdata_i[3:0];
      else        req_keep = (req_q & wdata_i[3:0]) | (wdata_i[7:4] & wdata_i[3:0]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '1;
      lvl_q <= LVL_IDLE;
    end else begin
      req_q <= req_keep | set_i;  // a new pulse beats a same-cycle clear
      if (wr1_i && !IS_NMI) begin
        lvl_q <= wdata_i[6:4];
        en_q  <= wdata_i[3:0];
      end
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/icu_resolve.sv
module icu_resolve
  import icu_pkg::*;
#(
  parameter int NUM_GROUPS = 25,
  parameter int NUM_NMI    = 2,
  localparam int GW        = $clog2(NUM_GROUPS)
) (
  input  logic [NUM_GROUPS-1:0] pend_i,
  input  lvl_t                  lvl_i [NUM_GROUPS],
  output logic [GW-1:0]         win_grp_o,
  output lvl_t                  win_lvl_o
);
  always_comb begin
    win_lvl_o = LVL_IDLE;
    win_grp_o = '0;
    // strict compare: earlier group keeps a tie
    for (int g = NUM_NMI; g < NUM_GROUPS; g++) begin
      if (pend_i[g] && (lvl_i[g] < win_lvl_o)) begin
        win_lvl_o = lvl_i[g];
        win_grp_o = GW'(g);
      end
    end
  end
endmodule

// File: rtl/icu_accept.sv
module icu_accept
  import icu_pkg::*;
#(
  parameter int GW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ack_i,
  input  lvl_t          ack_level_i,
  input  lvl_t          cur_level_i,
  input  logic [GW-1:0] win_grp_i,
  output logic [GW-1:0] agr_o,
  output logic          err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      agr_o <= '0;
      err_o <= 1'b0;
    end else if (ack_i) begin
      if (ack_level_i == cur_level_i) agr_o <= win_grp_i;
      else                            err_o <= 1'b1;
    end
  end
endmodule

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import icu_pkg::*;
#(
  parameter int NUM_GROUPS = 25,
  parameter int NUM_NMI    = 2,
  parameter int ADDR_W     = 8,
  parameter int AGR_ADDR   = 240,
  localparam int NIN       = NUM_GROUPS * LANES,
  localparam int GW        = $clog2(NUM_GROUPS),
  localparam int SEL_W     = ADDR_W - 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NIN-1:0]    set_req_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [7:0]        reg_rdata_o,
  input  logic              ack_i,
  input  logic [2:0]        ack_level_i,
  output logic [2:0]        level_o,
  output logic              nmi_o,
  output logic              ack_err_o
);
  lane_t req_w [NUM_GROUPS];
  lane_t en_w  [NUM_GROUPS];
  lvl_t  lvl_w [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_pend;
  logic [GW-1:0] win_grp, agr_q;
  lvl_t win_lvl;
  logic nmi_q;

  logic [SEL_W-1:0] grp_sel;
  logic [2:0]       byte_sel;
  logic             in_ctrl, is_agr;
  assign grp_sel  = reg_addr_i[ADDR_W-1:3];
  assign byte_sel = reg_addr_i[2:0];
  assign in_ctrl  = (32'(grp_sel) < NUM_GROUPS);
  assign is_agr   = (reg_addr_i == ADDR_W'(AGR_ADDR));

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = reg_we_i && in_ctrl && (32'(grp_sel) == g);
    icu_group #(.IS_NMI(g < NUM_NMI)) u_grp (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .set_i   (set_req_i[g*LANES +: LANES]),
      .wr0_i   (hit && (byte_sel == 3'd0)),
      .wr1_i   (hit && (byte_sel == 3'd1)),
      .wdata_i (reg_wdata_i),
      .req_o   (req_w[g]),
      .en_o    (en_w[g]),
      .lvl_o   (lvl_w[g])
    );
    assign grp_pend[g] = |(req_w[g] & en_w[g]);
  end

  icu_resolve #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI)) u_res (
    .pend_i    (grp_pend),
    .lvl_i     (lvl_w),
    .win_grp_o (win_grp),
    .win_lvl_o (win_lvl)
  );

  icu_accept #(.GW(GW)) u_acc (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ack_i       (ack_i),
    .ack_level_i (ack_level_i),
    .cur_level_i (win_lvl),
    .win_grp_i   (win_grp),
    .agr_o       (agr_q),
    .err_o       (ack_err_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nmi_q <= 1'b0;
    else         nmi_q <= |set_req_i[NUM_NMI*LANES-1:0];
  end

  always_comb begin
    reg_rdata_o = '0;
    if (is_agr) begin
      if (grp_pend[agr_q]) reg_rdata_o = 8'({agr_q, 2'b00});
    end else if (in_ctrl) begin
      if (32'(grp_sel) < NUM_NMI) begin
        if (byte_sel == 3'd0) reg_rdata_o = {4'b0, req_w[grp_sel]};
      end else begin
        if (byte_sel == 3'd0) reg_rdata_o = {req_w[grp_sel], req_w[grp_sel] & en_w[grp_sel]};
        else if (byte_sel == 3'd1) reg_rdata_o = {1'b0, lvl_w[grp_sel], en_w[grp_sel]};
      end
    end
  end

  assign level_o = win_lvl;
  assign nmi_o   = nmi_q;
endmodule

// File: rtl/icu_chk.sv
module icu_chk #(
  parameter int NUM_GROUPS = 25,
  parameter int NUM_NMI    = 2,
  parameter int GW         = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic [NUM_GROUPS*4-1:0] set_req_i,
  input logic                  reg_we_i,
  input logic                  ack_i,
  input logic [2:0]            ack_level_i,
  input logic [2:0]            level_o,
  input logic                  nmi_o,
  input logic                  ack_err_o,
  input logic [NUM_GROUPS-1:0] pend_i,
  input logic [GW-1:0]         agr_i
);
  logic nmi_set;
  logic [NUM_GROUPS-1:0] mask_pend;
  assign nmi_set   = |set_req_i[NUM_NMI*4-1:0];
  assign mask_pend = pend_i >> NUM_NMI;

  p_nmi_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nmi_set |=> nmi_o);
  p_nmi_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nmi_set |=> !nmi_o);
  p_idle_level_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_pend == '0) |-> (level_o == 3'd7));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_err_o |=> ack_err_o);
  p_bad_ack_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && (ack_level_i != level_o)) |=> (ack_err_o && $stable(agr_i)));
  p_agr_write_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && !ack_i) |=> $stable(agr_i));
endmodule

bind grp_irq_ctrl icu_chk #(.NUM_GROUPS(NUM_GROUPS), .NUM_NMI(NUM_NMI), .GW(GW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .set_req_i   (set_req_i),
  .reg_we_i    (reg_we_i),
  .ack_i       (ack_i),
  .ack_level_i (ack_level_i),
  .level_o     (level_o),
  .nmi_o       (nmi_o),
  .ack_err_o   (ack_err_o),
  .pend_i      (grp_pend),
  .agr_i       (agr_q)
);

// File: tb/grp_irq_ctrl_test.sv
module grp_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 25;
  localparam int NI = NG * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0] set_req = '0;
  logic we = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic ack = 1'b0;
  logic [2:0] ack_lvl = '0;
  logic [2:0] level;
  logic nmi, err;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  int m_req [NG];
  int m_en  [NG];
  int m_lvl [NG];
  int m_agr, m_err, m_nmi;

  always #(CLK_PERIOD/2) clk = ~clk;

  grp_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .set_req_i(set_req),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .ack_i(ack), .ack_level_i(ack_lvl), .level_o(level), .nmi_o(nmi), .ack_err_o(err)
  );

  function automatic int m_win_grp();
    int best = 7, bg = 0;
    for (int g = 2; g < NG; g++)
      if ((m_req[g] & m_en[g]) != 0 && m_lvl[g] < best) begin best = m_lvl[g]; bg = g; end
    return bg;
  endfunction

  function automatic int m_level();
    int bg = m_win_grp();
    return (bg == 0) ? 7 : m_lvl[bg];
  endfunction

  function automatic int m_read(int a);
    int g = a / 8, b = a % 8;
    if (a == 240) return ((m_req[m_agr] & m_en[m_agr]) != 0) ? (m_agr << 2) : 0;
    if (g >= NG) return 0;
    if (g < 2) return (b == 0) ? m_req[g] : 0;
    if (b == 0) return (m_req[g] << 4) | (m_req[g] & m_en[g]);
    if (b == 1) return (m_lvl[g] << 4) | m_en[g];
    return 0;
  endfunction

  function automatic string rd_tag(int a);
    if (a == 240) return "R9";
    if (a / 8 >= NG || a % 8 > 1) return "R12";
    if (a / 8 < 2) return "R5";
    return (a % 8 == 0) ? "R2" : "R3";
  endfunction

  task automatic model_reset();
    for (int g = 0; g < NG; g++) begin m_req[g] = 0; m_en[g] = 15; m_lvl[g] = 7; end
    m_agr = 0; m_err = 0; m_nmi = 0;
  endtask

  task automatic model_update();
    int cl = m_level(), wg = m_win_grp();
    int a = addr, w = wdata;
    if (ack) begin
      if (ack_lvl == cl) m_agr = wg; else m_err = 1;
    end
    if (we && a / 8 < NG) begin
      int g = a / 8;
      if (a % 8 == 0) begin
        if (g < 2) m_req[g] = m_req[g] & ~w & 15;
        else       m_req[g] = (m_req[g] & w & 15) | ((w >> 4) & w & 15);
      end else if (a % 8 == 1 && g >= 2) begin
        m_lvl[g] = (w >> 4) & 7;
        m_en[g]  = w & 15;
      end
    end
    m_nmi = 0;
    for (int i = 0; i < NI; i++)
      if (set_req[i]) begin
        m_req[i/4] = m_req[i/4] | (1 << (i % 4));
        if (i < 8) m_nmi = 1;
      end
  endtask

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk("R7 level", level, m_level());
    chk("R6 nmi", nmi, m_nmi);
    chk("R10 err", err, m_err);
    chk(rd_tag(addr), rdata, m_read(addr));
  endtask

  task automatic cyc();
    @(posedge clk);
    if (rst_n) model_update();
    @(negedge clk);
    compare();
    set_req = '0; we = 1'b0; ack = 1'b0;
  endtask

  task automatic wr(int a, int d);
    we = 1'b1; addr = 8'(a); wdata = 8'(d);
    cyc();
  endtask

  task automatic expect_rd(int a, int v, string tag);
    addr = 8'(a);
    cyc();
    chk(tag, rdata, v);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    compare();
    // R11 reset state
    chk("R11 level", level, 7);
    expect_rd(41, 8'h7F, "R11");
    expect_rd(240, 0, "R11");
    // R1 set pulse on lane 22 -> group 5 lane 2
    set_req[22] = 1'b1; cyc();
    expect_rd(40, 8'h44, "R1");
    wr(41, 8'h3F);
    chk("R7 level", level, 3);
    // R8 tie at level 3 between groups 5 and 9
    set_req[36] = 1'b1; cyc();
    wr(73, 8'h3F);
    ack = 1'b1; ack_lvl = 3'd3; cyc();
    expect_rd(240, 8'h14, "R8");
    // R10 mismatched ack
    wr(73, 8'h1F);
    chk("R7 level", level, 1);
    ack = 1'b1; ack_lvl = 3'd3; cyc();
    chk("R10 err", err, 1);
    expect_rd(240, 8'h14, "R10");
    // R9 accepted group lost its request
    wr(40, 8'h0B);
    expect_rd(240, 0, "R9");
    // R4 byte-0 write semantics
    wr(40, 8'hFF); expect_rd(40, 8'hFF, "R4");
    wr(40, 8'h33); expect_rd(40, 8'h33, "R4");
    wr(40, 8'h50); expect_rd(40, 8'h00, "R4");
    // R2 enable masks pending
    wr(73, 8'h10);
    expect_rd(72, 8'h10, "R2");
    chk("R7 level", level, 7);
    // R5 / R6 non-maskable group
    set_req[1] = 1'b1; cyc();
    chk("R6 nmi", nmi, 1);
    expect_rd(0, 8'h02, "R5");
    chk("R6 nmi", nmi, 0);
    wr(0, 8'h02); expect_rd(0, 0, "R5");
    wr(1, 8'hAB); expect_rd(1, 0, "R5");
    // R12 unmapped
    wr(42, 8'hFF); expect_rd(42, 0, "R12");
    expect_rd(41, 8'h3F, "R12");
    expect_rd(200, 0, "R12");
    // R9 accepted-group writes ignored
    wr(240, 8'hFF); expect_rd(240, 0, "R9");
    // R4 same-cycle set wins over clear
    set_req[20] = 1'b1; wr(40, 8'h00);
    expect_rd(40, 8'h11, "R4");
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 3) == 0) set_req[$urandom_range(0, NI-1)] = 1'b1;
      if ($urandom_range(0, 3) == 0) begin
        we = 1'b1;
        wdata = 8'($urandom);
        addr = ($urandom_range(0, 9) == 0) ? 8'($urandom) : 8'($urandom_range(0, 24) * 8 + $urandom_range(0, 1));
      end else begin
        addr = ($urandom_range(0, 4) == 0) ? 8'd240 : 8'($urandom_range(0, 199));
      end
      if ($urandom_range(0, 5) == 0) begin
        ack = 1'b1;
        ack_lvl = ($urandom_range(0, 7) == 0) ? 3'($urandom) : 3'(m_level());
      end
      cyc();
    end
    finish_run();
  end
endmodule